// File: doc/BRIEF.md
# Asynchronous Parallel Flash Bus Cycle Generator

This block sits on the host side of an asynchronous parallel flash device. It accepts one synchronous read or write request at a time over a valid/ready handshake and turns it into a bus cycle on the active-low chip enable, output enable and write enable strobes, an address bus, and a split data bus. The split data bus has an output value, an output enable and an input value. All device timings are parameters counted in clock cycles.

After a read, chip enable and output enable stay low and the address is held. A following read that changes only address bits 3 down to 0 therefore completes with the shorter page latency. A request whose address equals the one still held on the open bus first raises chip enable for a gap, because the device only starts a new access on an address change. When no request arrives for a configurable number of cycles, chip enable is released and the device goes to standby. Read data returns with a single-cycle valid pulse.

Top module: `pbus_cycle_gen`

## Requirements
- R1: During and right after reset, chip enable, output enable and write enable are high (inactive), the host does not drive the data bus, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A random read (issued from standby, after a write, or to a new 16-word page) holds CE and OE low with WE high and the request address on the bus. The data bus is sampled max(TACC,TOE) clock edges after the accepting edge, and the sampled value appears on `rsp_rdata` with `rsp_valid` high in the following cycle.
- R3: A read accepted while the bus is open after a read, with the same address bits above bit 3 and a different value in bits 3..0, keeps CE and OE low and samples after TPACC edges instead.
- R4: A write spends one setup cycle with CE low and OE, WE high and the data bus not driven. WE is then low for TWP cycles with `bus_dq_out` driven, followed by one hold cycle with WE high and data still driven. The data bus is then released and `req_ready` returns.
- R5: OE and WE are never low in the same cycle.
- R6: The host drives the data bus only when OE was high in the previous cycle. After the host stops driving, OE stays high for at least one more cycle.
- R7: A request whose address equals the address held while CE is low first raises CE (OE, WE high) for TCEH cycles. It is then carried out as from standby.
- R8: With the bus open, IDLE_CYC consecutive cycles without an accepted request raise CE (standby); the address is held.
- R9: A request accepted on the same edge on which the idle count expires is served from the open state; the bus does not go to standby.
- R10: `req_ready` is 1 only in standby or with the bus open. `req_valid` while `req_ready` is 0 has no effect on the bus.
- R11: Each read yields exactly one single-cycle `rsp_valid` pulse; writes yield none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DW | Read data |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_addr | output | AW | Bus address |
| bus_dq_out | output | DW | Data driven to the device |
| bus_dq_oe | output | 1 | Host drives the data bus |
| bus_dq_in | input | DW | Data returned by the device |

## Verification
The collision that matters is a new request landing on the same edge on which the idle counter expires. The bench provokes it by draining a transfer and waiting exactly IDLE_CYC-1 open cycles before presenting the next request. It then expects the access to proceed from the open state: a page read keeps the short latency, and CE does not rise. A second overlap, a request held valid while the block is busy, is provoked by presenting each request before the previous transfer ends. The bench judges it by comparing every bus pin and handshake output on every cycle against a queue-driven reference that models only when `req_ready` is high.

// File: rtl/pbus_pkg.sv
// Shared types for the parallel bus cycle generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pbus_pkg;

    // Sequencer states; the open states keep CE low between accesses
    typedef enum logic [2:0] {
        S_STBY    = 3'd0,
        S_RD      = 3'd1,
        S_OPEN_RD = 3'd2,
        S_WSET    = 3'd3,
        S_WPULSE  = 3'd4,
        S_WHOLD   = 3'd5,
        S_OPEN_WR = 3'd6,
        S_CEGAP   = 3'd7
    } pbus_state_e;

    // Larger of two cycle counts
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pbus_lat_timer.sv
// Down-counting latency timer shared by read, write-pulse and CE-gap phases.
// Assumes a load value of at least 1; `last` flags the final counted cycle.
module pbus_lat_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          last
);

    logic [TW-1:0] cnt_q;

    // Load a new count or step down towards zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    // The phase ends on the edge at which one cycle remains
    assign last = (cnt_q == TW'(1));

endmodule

// File: rtl/pbus_idle_mon.sv
// Counts consecutive open-bus cycles without an accepted request.
// Assumes IDLE_CYC >= 1; `expire` is high in the last allowed idle cycle.
module pbus_idle_mon #(
    parameter int IDLE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic clear,
    output logic expire
);

    localparam int IW = $clog2(IDLE_CYC + 1);

    logic [IW-1:0] idle_q;

    // Advance while the bus sits open, restart on any request or exit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (!active || clear) begin
            idle_q <= '0;
        end else if (idle_q != IW'(IDLE_CYC - 1)) begin
            idle_q <= idle_q + IW'(1);
        end
    end

    // Expiry is taken only when no request is accepted in this cycle
    assign expire = active && (idle_q == IW'(IDLE_CYC - 1));

endmodule

// File: rtl/pbus_addr_cmp.sv
// Compares a new request address with the address held on the bus.
// Assumes AW > PB; the low PB bits select the word inside a page.
module pbus_addr_cmp #(
    parameter int AW = 20,
    parameter int PB = 4
) (
    input  logic [AW-1:0] held_addr,
    input  logic [AW-1:0] new_addr,
    output logic          same_word,
    output logic          same_page
);

    // Full and page-level equality, no state
    always_comb begin
        same_word = (held_addr == new_addr);
        same_page = (held_addr[AW-1:PB] == new_addr[AW-1:PB]);
    end

endmodule

// File: rtl/pbus_cycle_gen.sv
// Host-side cycle generator for an asynchronous parallel flash bus.
// Turns one valid/ready request at a time into CE/OE/WE strobe sequences.
// Keeps CE low between accesses for page reads and forces a CE gap for
// repeated addresses. Assumes all timing parameters are >= 1 clock cycle.
// All bus outputs are registered.
module pbus_cycle_gen
    import pbus_pkg::*;
#(
    parameter int AW       = 20,
    parameter int DW       = 16,
    parameter int PB       = 4,
    parameter int TACC     = 5,
    parameter int TOE      = 3,
    parameter int TPACC    = 2,
    parameter int TWP      = 3,
    parameter int TCEH     = 2,
    parameter int IDLE_CYC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          bus_ce_n,
    output logic          bus_oe_n,
    output logic          bus_we_n,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dq_out,
    output logic          bus_dq_oe,
    input  logic [DW-1:0] bus_dq_in
);

    localparam int LFULL = max2(TACC, TOE);
    localparam int TMAX  = max2(max2(LFULL, TPACC), max2(TWP, TCEH));
    localparam int TW    = $clog2(TMAX + 1);
    localparam logic [TW-1:0] LFULL_V = TW'(LFULL);
    localparam logic [TW-1:0] TPACC_V = TW'(TPACC);
    localparam logic [TW-1:0] TWP_V   = TW'(TWP);
    localparam logic [TW-1:0] TCEH_V  = TW'(TCEH);

    pbus_state_e   state_q, state_d;
    logic          t_load, t_last;
    logic [TW-1:0] t_val;
    logic          accept, is_open, idle_exp;
    logic          same_word, same_page;
    logic          pend_wr_q;

    // Handshake: only standby and the open states take a request
    assign req_ready = (state_q == S_STBY) || (state_q == S_OPEN_RD) ||
                       (state_q == S_OPEN_WR);
    assign accept    = req_valid && req_ready;
    assign is_open   = (state_q == S_OPEN_RD) || (state_q == S_OPEN_WR);

    pbus_lat_timer #(.TW(TW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    pbus_idle_mon #(.IDLE_CYC(IDLE_CYC)) idle_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (is_open),
        .clear  (accept),
        .expire (idle_exp)
    );

    pbus_addr_cmp #(.AW(AW), .PB(PB)) cmp_i (
        .held_addr (bus_addr),
        .new_addr  (req_addr),
        .same_word (same_word),
        .same_page (same_page)
    );

    // Next-state selection and latency timer loading
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = LFULL_V;
        unique case (state_q)
            S_STBY: begin
                if (accept) begin
                    if (req_write) begin
                        state_d = S_WSET;
                    end else begin
                        state_d = S_RD;
                        t_load  = 1'b1;
                    end
                end
            end
            S_OPEN_RD, S_OPEN_WR: begin
                if (accept) begin
                    if (same_word) begin
                        state_d = S_CEGAP;
                        t_load  = 1'b1;
                        t_val   = TCEH_V;
                    end else if (req_write) begin
                        state_d = S_WSET;
                    end else begin
                        state_d = S_RD;
                        t_load  = 1'b1;
                        if ((state_q == S_OPEN_RD) && same_page) begin
                            t_val = TPACC_V;
                        end
                    end
                end else if (idle_exp) begin
                    state_d = S_STBY;
                end
            end
            S_RD: begin
                if (t_last) begin
                    state_d = S_OPEN_RD;
                end
            end
            S_WSET: begin
                state_d = S_WPULSE;
                t_load  = 1'b1;
                t_val   = TWP_V;
            end
            S_WPULSE: begin
                if (t_last) begin
                    state_d = S_WHOLD;
                end
            end
            S_WHOLD: begin
                state_d = S_OPEN_WR;
            end
            S_CEGAP: begin
                if (t_last) begin
                    if (pend_wr_q) begin
                        state_d = S_WSET;
                    end else begin
                        state_d = S_RD;
                        t_load  = 1'b1;
                    end
                end
            end
            default: state_d = S_STBY;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_STBY;
            pend_wr_q  <= 1'b0;
            bus_addr   <= '0;
            bus_dq_out <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                pend_wr_q  <= req_write;
                bus_addr   <= req_addr;
                bus_dq_out <= req_wdata;
            end
        end
    end

    // Registered strobe decode from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ce_n  <= 1'b1;
            bus_oe_n  <= 1'b1;
            bus_we_n  <= 1'b1;
            bus_dq_oe <= 1'b0;
        end else begin
            bus_ce_n  <= (state_d == S_STBY) || (state_d == S_CEGAP);
            bus_oe_n  <= !((state_d == S_RD) || (state_d == S_OPEN_RD));
            bus_we_n  <= (state_d != S_WPULSE);
            bus_dq_oe <= (state_d == S_WPULSE) || (state_d == S_WHOLD);
        end
    end

    // Read data capture at the end of the access latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (state_q == S_RD) && t_last;
            if ((state_q == S_RD) && t_last) begin
                rsp_rdata <= bus_dq_in;
            end
        end
    end

    // R5
    no_oe_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_oe_n && !bus_we_n));

    // R6
    drive_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dq_oe |-> (bus_oe_n && $past(bus_oe_n)));

    // R6
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_dq_oe) |-> bus_oe_n);

    // R4
    we_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_we_n) |-> bus_dq_oe);

    // R7
    ce_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !bus_ce_n && (req_addr == bus_addr)) |=> bus_ce_n);

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> $stable(bus_addr));

    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/pbus_cycle_gen_tb.sv
`timescale 1ns/1ps
// Cycle-by-cycle bench: a queue of expected bus states per accepted request.
module pbus_cycle_gen_tb_top;

    localparam int AW = 20, DW = 16;
    localparam int TACC = 5, TOE = 3, TPACC = 2, TWP = 3, TCEH = 2, IDLE_CYC = 6;
    localparam int LFULL = (TACC > TOE) ? TACC : TOE;
    localparam int M_STBY = 0, M_ORD = 1, M_OWR = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, bus_ce_n, bus_oe_n, bus_we_n, bus_dq_oe;
    logic [DW-1:0] rsp_rdata, bus_dq_out, bus_dq_in;
    logic [AW-1:0] bus_addr;

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return {a[11:0], a[19:16]} ^ 16'h5A3C;
    endfunction

    // Device model: drives data while selected and output-enabled
    assign bus_dq_in = (!bus_ce_n && !bus_oe_n) ? memf(bus_addr) : '0;

    pbus_cycle_gen #(.AW(AW), .DW(DW), .PB(4), .TACC(TACC), .TOE(TOE), .TPACC(TPACC),
                     .TWP(TWP), .TCEH(TCEH), .IDLE_CYC(IDLE_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_ce_n(bus_ce_n),
        .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_addr(bus_addr),
        .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe), .bus_dq_in(bus_dq_in));

    typedef struct packed {
        logic ce, oe, we, dq, rdy, rsp;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        int tag;
    } ent_t;

    ent_t q[$];
    int mstate = M_STBY, midle = 0;
    logic [AW-1:0] maddr = '0;
    int checks = 0, fails = 0;
    logic prev_dqoe = 1'b0, last_acc = 1'b0;
    bit done = 0;

    function automatic string tname(input int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
            5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
            9: return "R9";  10: return "R10"; default: return "R11";
        endcase
    endfunction

    function automatic ent_t mk(input logic ce, oe, we, dq, rdy, rsp,
                                input logic [AW-1:0] a, input logic [DW-1:0] d, input int t);
        ent_t e;
        e.ce = ce; e.oe = oe; e.we = we; e.dq = dq; e.rdy = rdy; e.rsp = rsp;
        e.addr = a; e.data = d; e.tag = t;
        return e;
    endfunction

    task automatic chk(input bit ok, input int t, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tname(t), what, act, exp, $time);
        end
    endtask

    // Model of an accepted request: pushes the expected per-cycle bus trace
    task automatic model_accept(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        bit timeout, same;
        int lat, tg;
        timeout = (mstate != M_STBY) && (midle == IDLE_CYC - 1);
        same = (mstate != M_STBY) && (a == maddr);
        if (same)
            for (int k = 0; k < TCEH; k++) q.push_back(mk(1, 1, 1, 0, 0, 0, a, '0, 7));
        if (w) begin
            q.push_back(mk(0, 1, 1, 0, 0, 0, a, d, 4));
            for (int k = 0; k < TWP; k++) q.push_back(mk(0, 1, 0, 1, 0, 0, a, d, 4));
            q.push_back(mk(0, 1, 1, 1, 0, 0, a, d, 4));
            q.push_back(mk(0, 1, 1, 0, 1, 0, a, d, 4));
            mstate = M_OWR;
        end else begin
            if (mstate == M_ORD && !same && a[AW-1:4] == maddr[AW-1:4]) begin
                lat = TPACC; tg = 3;
            end else begin
                lat = LFULL; tg = 2;
            end
            for (int k = 0; k < lat; k++) q.push_back(mk(0, 0, 1, 0, 0, 0, a, '0, tg));
            q.push_back(mk(0, 0, 1, 0, 1, 1, a, memf(a), tg));
            mstate = M_ORD;
        end
        if (timeout) foreach (q[k]) q[k].tag = 9;
        maddr = a;
        midle = 0;
    endtask

    // One cycle: compare at the falling edge, then drive inputs for the next edge
    task automatic tick(input logic v, input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        ent_t e;
        @(negedge clk);
        if (q.size() > 0) e = q.pop_front();
        else if (mstate == M_STBY) e = mk(1, 1, 1, 0, 1, 0, maddr, '0, 8);
        else if (mstate == M_ORD) e = mk(0, 0, 1, 0, 1, 0, maddr, '0, 8);
        else e = mk(0, 1, 1, 0, 1, 0, maddr, '0, 8);
        chk({bus_ce_n, bus_oe_n, bus_we_n, bus_dq_oe} == {e.ce, e.oe, e.we, e.dq}, e.tag, "strobes",
            64'({bus_ce_n, bus_oe_n, bus_we_n, bus_dq_oe}), 64'({e.ce, e.oe, e.we, e.dq}));
        chk(bus_addr == e.addr, e.tag, "addr", 64'(bus_addr), 64'(e.addr));
        chk(req_ready == e.rdy, 10, "req_ready", 64'(req_ready), 64'(e.rdy));
        chk(rsp_valid == e.rsp, 11, "rsp_valid", 64'(rsp_valid), 64'(e.rsp));
        if (e.rsp) chk(rsp_rdata == e.data, e.tag, "rsp_rdata", 64'(rsp_rdata), 64'(e.data));
        if (e.dq) chk(bus_dq_out == e.data, 4, "bus_dq_out", 64'(bus_dq_out), 64'(e.data));
        chk(!(!bus_oe_n && !bus_we_n), 5, "oe/we overlap", 64'({bus_oe_n, bus_we_n}), 64'b11);
        if (prev_dqoe) chk(bus_oe_n, 6, "turnaround oe_n", 64'(bus_oe_n), 64'd1);
        prev_dqoe = bus_dq_oe;
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        last_acc = 1'b0;
        if (v && e.rdy) begin
            model_accept(w, a, d);
            last_acc = 1'b1;
        end else if (q.size() == 0 && mstate != M_STBY) begin
            if (midle == IDLE_CYC - 1) mstate = M_STBY;
            else midle++;
        end
    endtask

    task automatic issue(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        do tick(1'b1, w, a, d); while (!last_acc);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick(1'b0, 1'b0, '0, '0);
    endtask

    task automatic drain();
        while (q.size() > 0) tick(1'b0, 1'b0, '0, '0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk({bus_ce_n, bus_oe_n, bus_we_n, bus_dq_oe, req_ready, rsp_valid} == 6'b111010, 1,
            "reset outputs", 64'({bus_ce_n, bus_oe_n, bus_we_n, bus_dq_oe, req_ready, rsp_valid}),
            64'b111010);
        rst_n = 1'b1;
        idle(2);
        issue(0, 20'h01230, '0);          // R2 random read from standby
        issue(0, 20'h01235, '0);          // R3 page read
        issue(0, 20'h0123F, '0);          // R3 page read
        issue(0, 20'h0123F, '0);          // R7 same address, CE gap
        issue(0, 20'h04560, '0);          // R2 new page
        issue(1, 20'h04560, 16'hBEEF);    // R7 write to held address
        issue(1, 20'h00777, 16'h1234);    // R4 write after write
        issue(0, 20'h00778, '0);          // R2 read after write, turnaround
        drain();
        idle(IDLE_CYC + 3);               // R8 standby after idle
        issue(1, 20'h00100, 16'hA5A5);    // R4 write from standby
        issue(1, 20'h00101, 16'h5A5A);
        drain();
        idle(IDLE_CYC - 2);
        issue(0, 20'h00102, '0);          // R9 request on the expiry edge
        drain();
        idle(IDLE_CYC - 2);
        issue(0, 20'h00103, '0);          // R9 page read on the expiry edge
        drain();
        idle(IDLE_CYC + 1);
        issue(0, 20'h00103, '0);          // R8 same address from standby: no gap
        for (int i = 0; i < 24; i++) begin
            logic [AW-1:0] a;
            a = 20'h20000 + 20'(i * 37);
            case (i % 4)
                0: issue(0, a, '0);
                1: issue(0, {maddr[AW-1:4], 4'(i)}, '0);
                2: issue(1, a, 16'(i * 263));
                default: issue(0, maddr, '0);
            endcase
            if (i % 5 == 0) idle(IDLE_CYC + 2);
        end
        drain();
        idle(4);
        done = 1;
        finish_run();
    end

endmodule